// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Register

This block takes a 23-bit control word from a three-wire serial port. The port has a bit clock, a data line and a latch strobe. The block samples all three lines with its own system clock. While the strobe is low, each rising edge of the bit clock shifts the data line into a shared shift register, most significant bit first. A rising strobe copies the register into one of two holding latches. The last bit shifted in picks the latch. The feedback latch holds the main and swallow counts and the phase-output control. The reference latch holds the reference count and two test bits.

The latched fields go as plain levels to the divider and output-control logic. They are configuration, not a data stream, so there is no valid/ready pairing. The strobe is the only commit point. An operate input puts the block in standby when it is low. Standby forces the phase-output enable low and keeps the contents of both latches.

Top module: `synth_ctl_reg`

## Requirements
- R1: While reset is asserted, every latched field reads zero and `pump_en` is low, so the phase output defaults to high impedance.
- R2: `ser_data` is sampled on each rising `ser_clk` while `ser_le` is low, most significant bit first. Bit 1 is the first bit shifted and bit 23 the last.
- R3: On a rising `ser_le` with bit 23 = 1, `fb_main` takes bits 1–13 (bit 1 is its MSB) and `fb_swallow` takes bits 14–18 (bit 14 is its MSB).
- R4: On a rising `ser_le` with bit 23 = 0, `ref_count` takes bits 10–20 (bit 10 is its MSB). `ref_test` takes bit 8 as its bit 1 and bit 9 as its bit 0.
- R5: A transfer changes only the latch that bit 23 selects. The other latch keeps its value.
- R6: Rising `ser_clk` edges and `ser_data` changes while `ser_le` is high do not alter the shift register. This includes a clock edge seen in the same cycle as the strobe's rising edge.
- R7: If more or fewer than 23 bits precede the strobe, the last 23 bits shifted are transferred. No error is flagged.
- R8: `pump_en` is high only when the feedback latch holds bits 21–22 = 11 and `operate` is high. The codes 00, 01 and 10 keep it low.
- R9: Both latches hold their contents while `operate` is low and whenever no strobe rises.
- R10: Bits 19–20 of a feedback word, and bits 1–7 and 21–22 of a reference word, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is shifted on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; a rising edge commits the word |
| operate | input | 1 | High = operate, low = standby |
| ref_count | output | 11 | Reference divider count |
| ref_test | output | 2 | Test bits from the reference word |
| fb_main | output | 13 | Main counter value |
| fb_swallow | output | 5 | Swallow counter value |
| pump_en | output | 1 | Phase-output drive enable (low = high impedance) |

## Verification
A rising bit clock and a rising strobe can land in the same sampled cycle. In that case the design must commit the register as it stood and drop the new bit. The bench provokes this by raising `ser_clk` and `ser_le` on the same system clock, with a data value that would change the committed fields if it were shifted in. It then compares the outputs with a model that ignores that bit. A follow-up word confirms the dropped bit also left no trace in the register.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int WORD_W  = 23;
  localparam int MAIN_W  = 13;
  localparam int SWAL_W  = 5;
  localparam int REFC_W  = 11;
  localparam int TEST_W  = 2;
  localparam int MODE_W  = 2;

  // Positions in the shift register after a full word: bit k of the word
  // (1 = first shifted) sits at index WORD_W - k.
  localparam int SEL_IDX   = 0;
  localparam int MODE_LSB  = 1;
  localparam int SWAL_LSB  = 5;
  localparam int MAIN_LSB  = SWAL_LSB + SWAL_W;
  localparam int REFC_LSB  = 3;
  localparam int TEST_LSB  = REFC_LSB + REFC_W;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [REFC_W-1:0] count;
  } ref_lat_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swallow;
    logic [MODE_W-1:0] mode;
  } fb_lat_t;

  localparam logic [MODE_W-1:0] MODE_DRIVE = 2'b11;
endpackage

// File: rtl/synth_ctl_edge_sync.sv
module synth_ctl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/synth_ctl_shift.sv
module synth_ctl_shift #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/synth_ctl_latches.sv
module synth_ctl_latches
  import synth_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output ref_lat_t          ref_q,
  output fb_lat_t           fb_q
);
  ref_lat_t ref_d;
  fb_lat_t  fb_d;
  logic     pick_fb;

  always_comb begin
    pick_fb        = word[SEL_IDX];
    ref_d.count    = word[REFC_LSB +: REFC_W];
    ref_d.test     = word[TEST_LSB +: TEST_W];
    fb_d.mode      = word[MODE_LSB +: MODE_W];
    fb_d.swallow   = word[SWAL_LSB +: SWAL_W];
    fb_d.main_cnt  = word[MAIN_LSB +: MAIN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      fb_q  <= '0;
    end else if (load) begin
      if (pick_fb) fb_q  <= fb_d;
      else         ref_q <= ref_d;
    end
  end
endmodule

// File: rtl/synth_ctl_reg.sv
module synth_ctl_reg
  import synth_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  input  logic              operate,
  output logic [REFC_W-1:0] ref_count,
  output logic [TEST_W-1:0] ref_test,
  output logic [MAIN_W-1:0] fb_main,
  output logic [SWAL_W-1:0] fb_swallow,
  output logic              pump_en
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] raw_in, lvl, rise;
  logic              le_lvl, load, shift_en;
  logic [WORD_W-1:0] sr_word;
  ref_lat_t          ref_q;
  fb_lat_t           fb_q;

  assign raw_in = {ser_le, ser_data, ser_clk};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_sync
      synth_ctl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in[g]),
        .level(lvl[g]), .rise(rise[g])
      );
    end
  endgenerate

  assign le_lvl   = lvl[2];
  assign load     = rise[2];
  assign shift_en = rise[0] & ~le_lvl;

  synth_ctl_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(lvl[1]), .word(sr_word)
  );

  synth_ctl_latches u_lat (
    .clk(clk), .rst_n(rst_n), .load(load), .word(sr_word),
    .ref_q(ref_q), .fb_q(fb_q)
  );

  assign ref_count  = ref_q.count;
  assign ref_test   = ref_q.test;
  assign fb_main    = fb_q.main_cnt;
  assign fb_swallow = fb_q.swallow;
  assign pump_en    = operate && (fb_q.mode == MODE_DRIVE);
endmodule

// File: rtl/synth_ctl_chk.sv
module synth_ctl_chk
  import synth_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              le_lvl,
  input logic              load,
  input logic              operate,
  input logic [WORD_W-1:0] sr_word,
  input logic [REFC_W-1:0] ref_count,
  input logic [TEST_W-1:0] ref_test,
  input logic [MAIN_W-1:0] fb_main,
  input logic [SWAL_W-1:0] fb_swallow,
  input logic              pump_en
);
  AST_NO_SHIFT_UNDER_LE: assert property (@(posedge clk) disable iff (!rst_n)
    le_lvl |=> $stable(sr_word)); // R6
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(ref_count) && $stable(ref_test) && $stable(fb_main) && $stable(fb_swallow))); // R9
  AST_REF_SEL_KEEPS_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sr_word[SEL_IDX]) |=> ($stable(fb_main) && $stable(fb_swallow))); // R5
  AST_FB_SEL_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (load && sr_word[SEL_IDX]) |=> ($stable(ref_count) && $stable(ref_test))); // R5
  AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !operate |-> !pump_en); // R8
  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (ref_count == '0 && fb_main == '0 && !pump_en); // R1
    end
  end
endmodule

bind synth_ctl_reg synth_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .le_lvl(le_lvl), .load(load), .operate(operate),
  .sr_word(sr_word), .ref_count(ref_count), .ref_test(ref_test),
  .fb_main(fb_main), .fb_swallow(fb_swallow), .pump_en(pump_en)
);

// File: tb/tb_synth_ctl_reg.sv
`timescale 1ns/1ps
module tb_synth_ctl_reg;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_le = 0, operate = 1;
  logic [10:0] ref_count;
  logic [1:0]  ref_test;
  logic [12:0] fb_main;
  logic [4:0]  fb_swallow;
  logic        pump_en;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [22:0] m_sr = '0;
  logic [10:0] m_rc = '0;
  logic [1:0]  m_rt = '0;
  logic [12:0] m_main = '0;
  logic [4:0]  m_sw = '0;
  logic [1:0]  m_mode = '0;

  always #10 clk = ~clk;

  synth_ctl_reg dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_pump(input logic [1:0] mode, input logic op);
    return op && (mode == 2'b11);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1;
    repeat (4) @(negedge clk);
    ser_clk = 0;
    repeat (2) @(negedge clk);
    m_sr = {m_sr[21:0], b};
  endtask

  task automatic model_commit();
    if (m_sr[0]) begin
      m_main = m_sr[22:10]; m_sw = m_sr[9:5]; m_mode = m_sr[2:1];
    end else begin
      m_rc = m_sr[13:3]; m_rt = m_sr[15:14];
    end
  endtask

  // strobe; optionally toggle the bit clock while strobe is high
  task automatic strobe(input int junk_clks);
    @(negedge clk) ser_le = 1;
    model_commit();
    repeat (4) @(negedge clk);
    for (int i = 0; i < junk_clks; i++) begin
      ser_data = $urandom; ser_clk = 1;
      repeat (3) @(negedge clk);
      ser_clk = 0;
      repeat (3) @(negedge clk);
    end
    ser_le = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_word(input logic [22:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit((i < 23) ? w[i] : logic'($urandom));
  endtask

  task automatic check_all(input string req);
    chk({req, " ref_count"}, 32'(ref_count), 32'(m_rc));
    chk({req, " ref_test"}, 32'(ref_test), 32'(m_rt));
    chk({req, " fb_main"}, 32'(fb_main), 32'(m_main));
    chk({req, " fb_swallow"}, 32'(fb_swallow), 32'(m_sw));
    chk({req, " pump_en"}, 32'(pump_en), 32'(exp_pump(m_mode, operate)));
  endtask

  initial begin
    #5ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1 after reset");

    // R3: main 314, swallow 4, drive code 11, select 1
    send_word({13'd314, 5'd4, 2'b00, 2'b11, 1'b1}, 23);
    strobe(0);
    check_all("R2 R3 feedback word");
    chk("R3 main", 32'(fb_main), 32'd314);
    chk("R8 drive", 32'(pump_en), 32'd1);

    // R4: count 192, test bits 1,0, select 0; R5 feedback kept
    send_word({7'd0, 2'b10, 11'd192, 2'b00, 1'b0}, 23);
    strobe(0);
    check_all("R4 R5 reference word");
    chk("R4 count", 32'(ref_count), 32'd192);

    // R10: don't-care bits set to ones change nothing
    send_word({7'h7f, 2'b10, 11'd192, 2'b11, 1'b0}, 23);
    strobe(0);
    chk("R10 ref dc", 32'(ref_count), 32'd192);
    send_word({13'd314, 5'd4, 2'b11, 2'b11, 1'b1}, 23);
    strobe(0);
    chk("R10 fb dc", 32'(fb_swallow), 32'd4);

    // R9 / R8: standby keeps contents, disables drive
    @(negedge clk) operate = 0;
    repeat (20) @(negedge clk);
    check_all("R9 standby");
    @(negedge clk) operate = 1;
    repeat (2) @(negedge clk);
    check_all("R9 resume");

    // R8: codes 00, 01, 10 keep drive low
    for (int c = 0; c < 3; c++) begin
      send_word({13'd100, 5'd7, 2'b00, 2'(c), 1'b1}, 23);
      strobe(0);
      chk("R8 code", 32'(pump_en), 32'd0);
    end

    // R6: clock pulses under strobe ignored; R7: short and long words
    send_word({13'd555, 5'd9, 2'b00, 2'b11, 1'b1}, 23);
    strobe(5);
    check_all("R6 junk under strobe");
    send_word(23'h12345, 9);
    strobe(0);
    check_all("R7 short word");
    send_word(23'h5a5a5, 30);
    strobe(0);
    check_all("R7 long word");

    // R6: clock edge and strobe rise in the same cycle
    send_word({13'd777, 5'd3, 2'b00, 2'b11, 1'b1}, 23);
    @(negedge clk) ser_data = 0;
    repeat (3) @(negedge clk);
    ser_clk = 1; ser_le = 1;
    model_commit();
    repeat (4) @(negedge clk);
    ser_clk = 0; ser_le = 0;
    repeat (6) @(negedge clk);
    check_all("R6 coincident edge");
    strobe(0);
    check_all("R6 coincident recommit");

    // random words of random length
    for (int n = 0; n < 40; n++) begin
      logic [22:0] w;
      int len;
      w = 23'($urandom);
      len = 20 + int'($urandom_range(0, 8));
      send_word(w, len);
      strobe(int'($urandom_range(0, 2)));
      check_all("R2 R5 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule